// File: doc/BRIEF.md
# Four-Entry Out-of-Order Integer Issue Queue

This block holds up to four decoded integer, multiply and load/store instructions while they wait for their operands and for a free execution unit. Each cycle the front end may write zero, one or two instructions into it. Each instruction carries a unit-class code, an identifier, two source tags and two operand-ready flags. A result-tag broadcast wakes up waiting operands. Only the two oldest slots can issue. Each of them is wired to its own set of three units. The upper slot may overtake a stalled lower slot, so instructions can leave out of age order.

Four units are fed: two simple integer pipes (the second handles only a subset of the first's operations), one multi-cycle unit and one load/store unit. Each unit gets a one-cycle issue strobe and an identifier. The queue reports its free-slot count so that dispatch never writes more than fits. Survivors shift down every cycle to keep the oldest entries at the bottom. A flush empties the queue in one cycle.

Top module: `gp_issue_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the queue is empty: `free_cnt_o` is 4 and no issue strobe is set.
- R2: `free_cnt_o` always equals 4 minus the number of held entries. It is computed from the registered state, so writes and issues in a cycle show up in the next cycle.
- R3: Each dispatch lane with its valid bit set writes one entry. Lane 0 is treated as older than lane 1. Lanes are accepted in that order only while `free_cnt_o` has room, and any further valid lane is dropped.
- R4: Only the two lowest slots (slot 0 = oldest, slot 1 = next) may issue. Entries in slots 2 and 3 never issue, even when ready.
- R5: Class codes are 0 = simple, either pipe; 1 = simple, first pipe only; 2 = multi-cycle; 3 = load/store. Issue strobe bits are 0 = simple pipe 1, 1 = simple pipe 2, 2 = multi-cycle unit, 3 = load/store unit, and unit u's identifier is `iss_id_o[u*IDW +: IDW]`. Slot 0 sends classes 0 and 1 to pipe 1, class 2 to the multi-cycle unit and class 3 to load/store.
- R6: Slot 1 sends class 0 to pipe 2, class 2 to the multi-cycle unit and class 3 to load/store. A class 1 entry never issues from slot 1.
- R7: An entry issues only when both of its operand-ready flags are set and its unit's `busy_i` bit is clear. When slot 0 cannot issue, slot 1 still issues if it can.
- R8: When slot 0 and slot 1 target the same unit and both could issue, slot 0 issues and slot 1 waits.
- R9: After a cycle, the surviving entries occupy the lowest slots in their original age order, and newly written entries sit above all survivors.
- R10: A cycle with `wake_vld_i` set marks every operand whose source tag equals `wake_tag_i` as ready from the next cycle on. This applies to held entries and to entries written in the same cycle.
- R11: `flush_i` suppresses every issue strobe in its cycle, discards that cycle's writes, and leaves the queue empty in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Clear the whole queue |
| disp_vld_i | input | DISP | Per-lane write request |
| disp_cls_i | input | 2*DISP | Class code of lane l at bits [2l+1:2l] |
| disp_id_i | input | DISP*IDW | Identifier of lane l at [l*IDW +: IDW] |
| disp_src_i | input | 2*DISP*TW | Source tag k of lane l at [(2l+k)*TW +: TW] |
| disp_rdy_i | input | 2*DISP | Ready flag of operand k of lane l at bit 2l+k |
| wake_vld_i | input | 1 | Result-tag broadcast valid |
| wake_tag_i | input | TW | Broadcast result tag |
| busy_i | input | 4 | Unit busy, one bit per unit |
| iss_vld_o | output | 4 | Issue strobe, one bit per unit |
| iss_id_o | output | 4*IDW | Identifier sent to each unit |
| free_cnt_o | output | $clog2(DEPTH+1) | Number of empty slots |

## Verification
A reference model in the bench predicts every strobe, identifier and free count, and is compared with the design in every cycle. Directed patterns come first. Each class is sent alone to slot 0 and then to slot 1, which separates the two slots' unit maps. A same-unit pair tells the priority rule apart from a merely ordered queue. A busy multi-cycle unit under a ready load/store shows whether slot 1 really overtakes. Ready entries parked in slots 2 and 3 confirm that the upper slots stay silent. Full-queue and one-free-slot writes show which lane is dropped. Late and same-cycle wakeups pin down the ready timing. After that, long random traffic with busy units, wakeups and occasional flushes exercises compaction order under every mix of issue outcomes.

// File: rtl/gpiq_pkg.sv
package gpiq_pkg;

  typedef enum logic [1:0] {
    CLS_ANY = 2'd0,
    CLS_U1  = 2'd1,
    CLS_MUL = 2'd2,
    CLS_LSU = 2'd3
  } cls_e;

  localparam int NUNIT = 4;
  localparam logic [1:0] U_SP1 = 2'd0;
  localparam logic [1:0] U_SP2 = 2'd1;
  localparam logic [1:0] U_MUL = 2'd2;
  localparam logic [1:0] U_LSU = 2'd3;

  typedef struct packed {
    logic       ok;
    logic [1:0] unit;
  } route_t;

  // Unit reached by a class from the lower (upper=0) or upper (upper=1) slot
  function automatic route_t route(input logic upper, input cls_e c);
    route_t r;
    case (c)
      CLS_ANY: begin r.ok = 1'b1;   r.unit = upper ? U_SP2 : U_SP1; end
      CLS_U1:  begin r.ok = !upper; r.unit = U_SP1;                 end
      CLS_MUL: begin r.ok = 1'b1;   r.unit = U_MUL;                 end
      default: begin r.ok = 1'b1;   r.unit = U_LSU;                 end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/giq_pick.sv
module giq_pick
  import gpiq_pkg::*;
#(
  parameter int IDW = 6
) (
  input  logic [1:0]           slot_vld,
  input  logic [1:0]           slot_rdy,
  input  cls_e                 slot_cls [2],
  input  logic [IDW-1:0]       slot_id  [2],
  input  logic [NUNIT-1:0]     busy,
  input  logic                 flush,
  output logic [1:0]           take,
  output logic [NUNIT-1:0]     iss_vld,
  output logic [NUNIT*IDW-1:0] iss_id
);

  route_t r_lo, r_hi;
  logic   go_lo, go_hi;

  always_comb begin
    r_lo  = route(1'b0, slot_cls[0]);
    r_hi  = route(1'b1, slot_cls[1]);
    go_lo = slot_vld[0] && slot_rdy[0] && !flush && r_lo.ok && !busy[r_lo.unit];
    go_hi = slot_vld[1] && slot_rdy[1] && !flush && r_hi.ok && !busy[r_hi.unit]
            && !(go_lo && (r_lo.unit == r_hi.unit));
    take    = {go_hi, go_lo};
    iss_vld = '0;
    iss_id  = '0;
    if (go_lo) begin
      iss_vld[r_lo.unit]               = 1'b1;
      iss_id[r_lo.unit*IDW +: IDW]     = slot_id[0];
    end
    if (go_hi) begin
      iss_vld[r_hi.unit]               = 1'b1;
      iss_id[r_hi.unit*IDW +: IDW]     = slot_id[1];
    end
  end

endmodule

// File: rtl/giq_next.sv
module giq_next
  import gpiq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDW   = 6,
  parameter int TW    = 5,
  parameter int DISP  = 2,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic [DEPTH-1:0]      vld_q,
  input  cls_e                  cls_q [DEPTH],
  input  logic [IDW-1:0]        id_q  [DEPTH],
  input  logic [1:0][TW-1:0]    src_q [DEPTH],
  input  logic [1:0]            rdy_q [DEPTH],
  input  logic [DEPTH-1:0]      gone,
  input  logic [CW-1:0]         free_cnt,
  input  logic                  flush,
  input  logic [DISP-1:0]       disp_vld,
  input  logic [2*DISP-1:0]     disp_cls,
  input  logic [DISP*IDW-1:0]   disp_id,
  input  logic [2*DISP*TW-1:0]  disp_src,
  input  logic [2*DISP-1:0]     disp_rdy,
  input  logic                  wake_vld,
  input  logic [TW-1:0]         wake_tag,
  output logic [DEPTH-1:0]      vld_d,
  output cls_e                  cls_d [DEPTH],
  output logic [IDW-1:0]        id_d  [DEPTH],
  output logic [1:0][TW-1:0]    src_d [DEPTH],
  output logic [1:0]            rdy_d [DEPTH]
);

  function automatic logic [1:0] woken(input logic [1:0] rdy,
                                       input logic [1:0][TW-1:0] src);
    logic [1:0] r;
    for (int k = 0; k < 2; k++)
      r[k] = rdy[k] | (wake_vld && (src[k] == wake_tag));
    return r;
  endfunction

  int n;
  int placed;
  logic [1:0][TW-1:0] lsrc;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_d[i] = 1'b0;
      cls_d[i] = cls_q[i];
      id_d[i]  = id_q[i];
      src_d[i] = src_q[i];
      rdy_d[i] = rdy_q[i];
    end
    n      = 0;
    placed = 0;
    lsrc   = '0;
    // survivors slide down in age order
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && !gone[i] && n < DEPTH) begin
        vld_d[n] = 1'b1;
        cls_d[n] = cls_q[i];
        id_d[n]  = id_q[i];
        src_d[n] = src_q[i];
        rdy_d[n] = woken(rdy_q[i], src_q[i]);
        n++;
      end
    end
    // new lanes land above survivors, limited by the registered free count
    for (int l = 0; l < DISP; l++) begin
      if (disp_vld[l] && placed < int'(free_cnt) && n < DEPTH) begin
        lsrc     = disp_src[l*2*TW +: 2*TW];
        vld_d[n] = 1'b1;
        cls_d[n] = cls_e'(disp_cls[l*2 +: 2]);
        id_d[n]  = disp_id[l*IDW +: IDW];
        src_d[n] = lsrc;
        rdy_d[n] = woken(disp_rdy[l*2 +: 2], lsrc);
        n++;
        placed++;
      end
    end
    if (flush) vld_d = '0;
  end

endmodule

// File: rtl/gp_issue_queue.sv
module gp_issue_queue
  import gpiq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDW   = 6,
  parameter int TW    = 5,
  parameter int DISP  = 2,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic [DISP-1:0]       disp_vld_i,
  input  logic [2*DISP-1:0]     disp_cls_i,
  input  logic [DISP*IDW-1:0]   disp_id_i,
  input  logic [2*DISP*TW-1:0]  disp_src_i,
  input  logic [2*DISP-1:0]     disp_rdy_i,
  input  logic                  wake_vld_i,
  input  logic [TW-1:0]         wake_tag_i,
  input  logic [NUNIT-1:0]      busy_i,
  output logic [NUNIT-1:0]      iss_vld_o,
  output logic [NUNIT*IDW-1:0]  iss_id_o,
  output logic [CW-1:0]         free_cnt_o
);

  logic [DEPTH-1:0]   vld_q, vld_d;
  cls_e               cls_q [DEPTH];
  cls_e               cls_d [DEPTH];
  logic [IDW-1:0]     id_q  [DEPTH];
  logic [IDW-1:0]     id_d  [DEPTH];
  logic [1:0][TW-1:0] src_q [DEPTH];
  logic [1:0][TW-1:0] src_d [DEPTH];
  logic [1:0]         rdy_q [DEPTH];
  logic [1:0]         rdy_d [DEPTH];

  logic [1:0]         take;
  logic [DEPTH-1:0]   gone;
  logic [1:0]         slot_rdy;
  cls_e               slot_cls [2];
  logic [IDW-1:0]     slot_id  [2];
  logic               pay_en;

  // free count from registered occupancy
  always_comb begin
    free_cnt_o = CW'(DEPTH);
    for (int i = 0; i < DEPTH; i++)
      free_cnt_o = free_cnt_o - CW'(vld_q[i]);
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign slot_rdy[s] = &rdy_q[s];
    assign slot_cls[s] = cls_q[s];
    assign slot_id[s]  = id_q[s];
  end

  giq_pick #(.IDW(IDW)) u_pick (
    .slot_vld (vld_q[1:0]),
    .slot_rdy (slot_rdy),
    .slot_cls (slot_cls),
    .slot_id  (slot_id),
    .busy     (busy_i),
    .flush    (flush_i),
    .take     (take),
    .iss_vld  (iss_vld_o),
    .iss_id   (iss_id_o)
  );

  assign gone = DEPTH'(take);

  giq_next #(.DEPTH(DEPTH), .IDW(IDW), .TW(TW), .DISP(DISP)) u_next (
    .vld_q    (vld_q),
    .cls_q    (cls_q),
    .id_q     (id_q),
    .src_q    (src_q),
    .rdy_q    (rdy_q),
    .gone     (gone),
    .free_cnt (free_cnt_o),
    .flush    (flush_i),
    .disp_vld (disp_vld_i),
    .disp_cls (disp_cls_i),
    .disp_id  (disp_id_i),
    .disp_src (disp_src_i),
    .disp_rdy (disp_rdy_i),
    .wake_vld (wake_vld_i),
    .wake_tag (wake_tag_i),
    .vld_d    (vld_d),
    .cls_d    (cls_d),
    .id_d     (id_d),
    .src_d    (src_d),
    .rdy_d    (rdy_d)
  );

  // payload moves only when something changes it
  assign pay_en = (|disp_vld_i) | (|take) | wake_vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (pay_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        cls_q[i] <= cls_d[i];
        id_q[i]  <= id_d[i];
        src_q[i] <= src_d[i];
        rdy_q[i] <= rdy_d[i];
      end
    end
  end

endmodule

// File: rtl/gp_issue_queue_chk.sv
module gp_issue_queue_chk #(
  parameter int DEPTH = 4,
  parameter int DISP  = 2,
  parameter int NU    = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_i,
  input logic [DISP-1:0] disp_vld_i,
  input logic [NU-1:0] busy_i,
  input logic [NU-1:0] iss_vld_o,
  input logic [CW-1:0] free_cnt_o
);

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld_o & busy_i) == '0);

  assert_two_ports_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_vld_o) <= 2);

  assert_flush_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> iss_vld_o == '0);

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> free_cnt_o == CW'(DEPTH));

  assert_idle_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && iss_vld_o == '0 && disp_vld_i == '0) |=> $stable(free_cnt_o));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && iss_vld_o == '0 && free_cnt_o == '0) |=> free_cnt_o == '0);

endmodule

bind gp_issue_queue gp_issue_queue_chk #(
  .DEPTH(DEPTH), .DISP(DISP), .NU(gpiq_pkg::NUNIT), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush_i    (flush_i),
  .disp_vld_i (disp_vld_i),
  .busy_i     (busy_i),
  .iss_vld_o  (iss_vld_o),
  .free_cnt_o (free_cnt_o)
);

// File: tb/gp_issue_queue_test.sv
`timescale 1ns/1ps
module gp_issue_queue_test;

  localparam int DEPTH = 4, IDW = 6, TW = 5, DISP = 2, CW = 3;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 flush_i;
  logic [DISP-1:0]      disp_vld_i;
  logic [2*DISP-1:0]    disp_cls_i;
  logic [DISP*IDW-1:0]  disp_id_i;
  logic [2*DISP*TW-1:0] disp_src_i;
  logic [2*DISP-1:0]    disp_rdy_i;
  logic                 wake_vld_i;
  logic [TW-1:0]        wake_tag_i;
  logic [3:0]           busy_i;
  logic [3:0]           iss_vld_o;
  logic [4*IDW-1:0]     iss_id_o;
  logic [CW-1:0]        free_cnt_o;

  always #5 clk = ~clk;

  gp_issue_queue uut (.*);

  typedef struct { int cls; int id; int s0; int s1; bit r0; bit r1; } ent_t;
  ent_t  q[$];
  int    checks = 0, errors = 0, next_id = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    flush_i = 0; disp_vld_i = '0; disp_cls_i = '0; disp_id_i = '0;
    disp_src_i = '0; disp_rdy_i = '0; wake_vld_i = 0; wake_tag_i = '0; busy_i = '0;
  endtask

  task automatic put(int l, int c, bit r0, bit r1, int s0, int s1);
    disp_vld_i[l]             = 1'b1;
    disp_cls_i[l*2 +: 2]      = 2'(c);
    disp_id_i[l*IDW +: IDW]   = IDW'(next_id);
    disp_src_i[(2*l)*TW +: TW]   = TW'(s0);
    disp_src_i[(2*l+1)*TW +: TW] = TW'(s1);
    disp_rdy_i[2*l]           = r0;
    disp_rdy_i[2*l+1]         = r1;
    next_id = (next_id + 1) % 64;
  endtask

  function automatic ent_t wk(ent_t e);
    ent_t r = e;
    if (wake_vld_i && e.s0 == int'(wake_tag_i)) r.r0 = 1;
    if (wake_vld_i && e.s1 == int'(wake_tag_i)) r.r1 = 1;
    return r;
  endfunction

  // one cycle: inputs already driven after a falling edge
  task automatic cyc();
    int u0, u1, exp_vld, exp_id[4], freeslots, taken;
    bit go0, go1;
    ent_t nq[$];
    ent_t ne;
    #1;
    exp_vld = 0; go0 = 0; go1 = 0; u0 = -1; u1 = -2;
    for (int u = 0; u < 4; u++) exp_id[u] = 0;
    if (!flush_i && q.size() > 0 && q[0].r0 && q[0].r1) begin
      u0 = (q[0].cls < 2) ? 0 : q[0].cls;
      go0 = !busy_i[u0];
    end
    if (!flush_i && q.size() > 1 && q[1].r0 && q[1].r1 && q[1].cls != 1) begin
      u1 = (q[1].cls == 0) ? 1 : q[1].cls;
      go1 = !busy_i[u1] && !(go0 && u0 == u1);
    end
    if (go0) begin exp_vld |= (1 << u0); exp_id[u0] = q[0].id; end
    if (go1) begin exp_vld |= (1 << u1); exp_id[u1] = q[1].id; end
    chk(cur_req, "R2 free count", int'(free_cnt_o), DEPTH - q.size());
    chk(cur_req, "strobes", int'(iss_vld_o), exp_vld);
    for (int u = 0; u < 4; u++)
      if (exp_vld[u] && iss_vld_o[u])
        chk(cur_req, $sformatf("unit %0d id", u), int'(iss_id_o[u*IDW +: IDW]), exp_id[u]);
    freeslots = DEPTH - q.size();
    if (!flush_i) begin
      for (int i = 0; i < q.size(); i++)
        if (!((i == 0 && go0) || (i == 1 && go1))) nq.push_back(wk(q[i]));
      taken = 0;
      for (int l = 0; l < DISP; l++)
        if (disp_vld_i[l] && taken < freeslots) begin
          ne.cls = int'(disp_cls_i[l*2 +: 2]);
          ne.id  = int'(disp_id_i[l*IDW +: IDW]);
          ne.s0  = int'(disp_src_i[(2*l)*TW +: TW]);
          ne.s1  = int'(disp_src_i[(2*l+1)*TW +: TW]);
          ne.r0  = disp_rdy_i[2*l];
          ne.r1  = disp_rdy_i[2*l+1];
          nq.push_back(wk(ne));
          taken++;
        end
    end
    q = nq;
    @(negedge clk);
    clr();
  endtask

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    #1;
    chk("R1", "free in reset", int'(free_cnt_o), 4);
    chk("R1", "strobes in reset", int'(iss_vld_o), 0);
    @(negedge clk);
    rst_n = 1;
    cyc();
    // R5: each class alone in slot 0
    cur_req = "R5";
    for (int c = 0; c < 4; c++) begin put(0, c, 1, 1, 0, 0); cyc(); cyc(); end
    // R6: slot 0 parked, slot 1 ready of each class
    for (int c = 0; c < 4; c++) begin
      cur_req = "R6";
      put(0, 0, 0, 0, 31, 31); put(1, c, 1, 1, 0, 0); cyc(); cyc(); cyc();
      cur_req = "R11"; flush_i = 1; cyc();
    end
    // R8 then R9: same unit, slot 0 first, then survivor shifts down
    cur_req = "R8"; put(0, 2, 1, 1, 0, 0); put(1, 2, 1, 1, 0, 0); cyc(); cyc();
    cur_req = "R9"; cyc(); cyc();
    // R7: busy multi-cycle unit, load/store in slot 1 overtakes
    cur_req = "R7"; put(0, 2, 1, 1, 0, 0); put(1, 3, 1, 1, 0, 0); cyc();
    busy_i = 4'b0100; cyc(); busy_i = 4'b0100; cyc(); cyc(); cyc();
    put(0, 0, 1, 0, 0, 31); cyc(); cyc();
    cur_req = "R11"; flush_i = 1; cyc();
    // R4: ready entries parked above two stalled ones
    cur_req = "R4"; put(0, 0, 0, 0, 31, 31); put(1, 0, 0, 0, 31, 31); cyc();
    put(0, 0, 1, 1, 0, 0); put(1, 3, 1, 1, 0, 0); cyc(); cyc();
    // R3: writes into a full queue dropped
    cur_req = "R3"; put(0, 3, 1, 1, 0, 0); put(1, 3, 1, 1, 0, 0); cyc(); cyc();
    cur_req = "R11"; flush_i = 1; put(0, 3, 1, 1, 0, 0); cyc(); cyc();
    // R3: one free slot, lane 0 taken
    cur_req = "R3"; put(0, 0, 0, 0, 31, 31); put(1, 0, 0, 0, 31, 31); cyc();
    put(0, 0, 0, 0, 31, 31); cyc();
    put(0, 1, 1, 1, 0, 0); put(1, 2, 1, 1, 0, 0); cyc(); cyc();
    cur_req = "R11"; flush_i = 1; cyc();
    // R10: late wakeup and same-cycle wakeup
    cur_req = "R10"; put(0, 0, 0, 1, 3, 0); cyc(); cyc();
    wake_vld_i = 1; wake_tag_i = 3; cyc(); cyc(); cyc();
    put(0, 3, 0, 0, 4, 4); wake_vld_i = 1; wake_tag_i = 4; cyc(); cyc(); cyc();
    // R11: flush with a ready entry in slot 0
    cur_req = "R11"; put(0, 0, 1, 1, 0, 0); cyc(); flush_i = 1; cyc(); cyc();
    // random traffic
    cur_req = "R9";
    for (int n = 0; n < 4000; n++) begin
      for (int l = 0; l < DISP; l++)
        if ($urandom % 2 == 0)
          put(l, int'($urandom % 4), ($urandom % 3) != 0, ($urandom % 3) != 0,
              int'($urandom % 8), int'($urandom % 8));
      wake_vld_i = ($urandom % 2) == 0;
      wake_tag_i = TW'($urandom % 8);
      for (int u = 0; u < 4; u++) busy_i[u] = ($urandom % 4) == 0;
      flush_i = ($urandom % 50) == 0;
      cyc();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule